// File: doc/BRIEF.md
# Multi-cycle 8-bit accumulator core (load/store/jump subset)

This block is a small multi-cycle processor core. It fetches opcodes one byte per machine cycle from a single-port byte memory and executes a subset of a classic accumulator instruction set. One machine cycle is one clock cycle, and each machine cycle makes at most one memory access. The architectural state is seven 8-bit registers (A, B, C, D, E, H, L), a zero flag and a carry flag, a 16-bit stack pointer and a 16-bit program counter. Registers pair as BC, DE and HL, with the first-named register as the high byte.

The supported subset covers these instructions:
- immediate loads into any of the seven registers
- two register moves
- accumulator loads and stores through BC, DE and HL
- HL post-increment and post-decrement addressing
- an immediate store through HL
- flag-neutral 16-bit increment and decrement of BC, DE, HL and SP
- relative jumps, unconditional and conditional on Z clear, Z set or C clear

Any other opcode raises a sticky illegal-instruction output and freezes the core until reset. No instruction in this subset writes the flags. They hold the value given by a parameter at reset.

Memory reads are combinational: `mem_rdata_i` must reflect `mem_addr_o` within the same cycle, and the core samples it at the end of that cycle. A write happens in a cycle where `mem_we_o` is high, with `mem_addr_o` and `mem_wdata_o` valid in that same cycle. In a cycle with no access, the address shows the program counter and the write enable is low.

Top module: `acc_core`

## Requirements
- R1: After reset the first fetch is from address RST_PC. Every instruction begins with one opcode fetch cycle at the current PC, after which PC is one higher.
- R2: An opcode of the form 00rrr110 with rrr not 110 (rrr: 000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 111 A) reads the next byte at PC into that register and takes 2 cycles.
- R3: Opcodes 0x02/0x12 write A to the address in BC/DE. Opcodes 0x0A/0x1A load A from that address. Each takes 2 cycles, and the access is in the second cycle.
- R4: Opcodes 0x22/0x2A store/load A at the address in HL and then add one to HL. Opcodes 0x32/0x3A do the same and then subtract one. Each takes 2 cycles.
- R5: Opcodes 00pp0011 add one and 00pp1011 subtract one (pp: 00 BC, 01 DE, 10 HL, 11 SP), modulo 65536. They take 2 cycles, make no memory write and leave the flags unchanged.
- R6: Opcode 0x36 reads an immediate byte at PC and writes it to the address in HL. It takes 3 cycles.
- R7: Opcode 0x18 reads a signed offset byte at PC and then adds it, sign-extended, to the incremented PC. It takes 3 cycles. Opcodes 0x20, 0x28 and 0x30 jump the same way only when Z is clear, Z is set or C is clear; a jump that is not taken takes 2 cycles.
- R8: Opcode 0x40 copies B to B and opcode 0x41 copies C to B, each in 1 cycle.
- R9: Any other opcode sets `illegal_o` from the next cycle until reset. From then on the core makes no write and holds its address.
- R10: Z is flag bit 7 and C is flag bit 4. Both are loaded from RST_FLAGS at reset, and no supported opcode changes them.
- R11: A memory write lasts exactly one cycle, with address and data valid in that cycle. Every write is the last cycle of its instruction, so the next cycle is an opcode fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 16 | Memory byte address for the current machine cycle |
| mem_wdata_o | output | 8 | Write data, valid when mem_we_o is high |
| mem_rdata_i | input | 8 | Combinational read data for mem_addr_o |
| mem_we_o | output | 1 | Write enable for the current cycle |
| illegal_o | output | 1 | Sticky unsupported-opcode indicator, core halted |

## Verification
The bench builds the core with RST_PC = 0x0100, RST_SP = 0x8000 and RST_FLAGS = 0x80, so Z is set and C is clear for the whole run. No instruction in the subset can change the flags, so this setting is what lets one program take the Z-set jump and the C-clear jump while skipping the Z-clear jump. A start address away from zero lets stores through HL wrap to 0x0000 and 0xFFFF without overwriting the program. It also shows that the first fetch follows the parameter. Forward and backward jumps, and a chain of increments and decrements through both 16-bit wrap points, are compared cycle by cycle against a queued behavioural model.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int NREG   = 8;
  localparam int RIDX_W = $clog2(NREG);
  localparam logic [RIDX_W-1:0] IDX_A = RIDX_W'(7);
  localparam logic [1:0] PAIR_HL = 2'd2;
  localparam logic [1:0] PAIR_SP = 2'd3;
  localparam int FLAG_Z_BIT = 7;
  localparam int FLAG_C_BIT = 4;

  typedef enum logic [1:0] {ST_FETCH, ST_M2, ST_M3, ST_HALT} state_e;
  typedef enum logic [2:0] {OP_MOV, OP_LDI, OP_STP, OP_LDP, OP_PAIR, OP_STIM, OP_JR, OP_ILL} kind_e;
  typedef enum logic [1:0] {HL_KEEP, HL_UP, HL_DOWN} hlstep_e;
  typedef enum logic [1:0] {CC_ALW, CC_NZ, CC_Z, CC_NC} cond_e;
  typedef enum logic [1:0] {AU_INC, AU_DEC, AU_REL} au_e;

  typedef struct packed {
    kind_e             kind;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] src;
    logic [1:0]        pair;
    logic              down;
    hlstep_e           hl;
    cond_e             cc;
  } dec_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [DATA_W-1:0] op_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.kind = OP_ILL;
    dec_o.dst  = op_i[5:3];
    dec_o.src  = op_i[2:0];
    dec_o.pair = op_i[5:4];
    dec_o.down = op_i[3];
    dec_o.hl   = HL_KEEP;
    dec_o.cc   = CC_ALW;
    case (op_i)
      8'h40, 8'h41: dec_o.kind = OP_MOV;
      8'h06, 8'h0E, 8'h16, 8'h1E, 8'h26, 8'h2E, 8'h3E: dec_o.kind = OP_LDI;
      8'h02, 8'h12: dec_o.kind = OP_STP;
      8'h22: begin dec_o.kind = OP_STP; dec_o.pair = PAIR_HL; dec_o.hl = HL_UP; end
      8'h32: begin dec_o.kind = OP_STP; dec_o.pair = PAIR_HL; dec_o.hl = HL_DOWN; end
      8'h0A, 8'h1A: dec_o.kind = OP_LDP;
      8'h2A: begin dec_o.kind = OP_LDP; dec_o.pair = PAIR_HL; dec_o.hl = HL_UP; end
      8'h3A: begin dec_o.kind = OP_LDP; dec_o.pair = PAIR_HL; dec_o.hl = HL_DOWN; end
      8'h03, 8'h13, 8'h23, 8'h33,
      8'h0B, 8'h1B, 8'h2B, 8'h3B: dec_o.kind = OP_PAIR;
      8'h36: dec_o.kind = OP_STIM;
      8'h18: dec_o.kind = OP_JR;
      8'h20: begin dec_o.kind = OP_JR; dec_o.cc = CC_NZ; end
      8'h28: begin dec_o.kind = OP_JR; dec_o.cc = CC_Z;  end
      8'h30: begin dec_o.kind = OP_JR; dec_o.cc = CC_NC; end
      default: dec_o.kind = OP_ILL;
    endcase
  end
endmodule

// File: rtl/acc_addr_unit.sv
module acc_addr_unit
  import acc_pkg::*;
#(
  parameter int W = ADDR_W
) (
  input  logic [W-1:0]      val_i,
  input  au_e               mode_i,
  input  logic [DATA_W-1:0] off_i,
  output logic [W-1:0]      res_o
);
  logic [W-1:0] off_sx;
  assign off_sx = {{(W-DATA_W){off_i[DATA_W-1]}}, off_i};

  always_comb begin
    case (mode_i)
      AU_DEC:  res_o = val_i - W'(1);
      AU_REL:  res_o = val_i + off_sx;
      default: res_o = val_i + W'(1);
    endcase
  end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
  import acc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RST_SP = 16'hFFFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_we_i,
  input  logic [RIDX_W-1:0] byte_idx_i,
  input  logic [DATA_W-1:0] byte_d_i,
  input  logic              pair_we_i,
  input  logic [1:0]        pair_idx_i,
  input  logic [ADDR_W-1:0] pair_d_i,
  input  logic [RIDX_W-1:0] byte_rd_idx_i,
  output logic [DATA_W-1:0] byte_rd_o,
  input  logic [1:0]        pair_rd_idx_i,
  output logic [ADDR_W-1:0] pair_rd_o,
  output logic [DATA_W-1:0] a_o,
  output logic [ADDR_W-1:0] hl_o
);
  logic [DATA_W-1:0] gpr [NREG];
  logic [ADDR_W-1:0] sp_q;
  logic              pair_gpr_we;

  assign pair_gpr_we = pair_we_i && (pair_idx_i != PAIR_SP);

  for (genvar i = 0; i < NREG; i++) begin : g_gpr
    localparam logic [1:0] MY_PAIR = 2'(i / 2);
    localparam bit         IS_HI   = (i % 2) == 0;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (byte_we_i && byte_idx_i == RIDX_W'(i)) q <= byte_d_i;
      else if (pair_gpr_we && pair_idx_i == MY_PAIR)
        q <= IS_HI ? pair_d_i[ADDR_W-1:DATA_W] : pair_d_i[DATA_W-1:0];
    end
    assign gpr[i] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= RST_SP;
    else if (pair_we_i && pair_idx_i == PAIR_SP) sp_q <= pair_d_i;
  end

  assign byte_rd_o = gpr[byte_rd_idx_i];
  assign pair_rd_o = (pair_rd_idx_i == PAIR_SP) ? sp_q
                   : {gpr[{pair_rd_idx_i, 1'b0}], gpr[{pair_rd_idx_i, 1'b1}]};
  assign a_o       = gpr[IDX_A];
  assign hl_o      = {gpr[{PAIR_HL, 1'b0}], gpr[{PAIR_HL, 1'b1}]};
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RST_PC    = 16'h0000,
  parameter logic [ADDR_W-1:0] RST_SP    = 16'hFFFE,
  parameter logic [DATA_W-1:0] RST_FLAGS = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic              illegal_o
);
  state_e            state_q, state_d;
  dec_t              ir_q, dec_w;
  logic [ADDR_W-1:0] pc_q, pc_nxt;
  logic [DATA_W-1:0] tmp_q;
  logic              flag_z_q, flag_c_q, ill_q;
  logic              pc_en, tmp_en, cond_ok;
  au_e               pc_mode, pair_mode;

  logic              byte_we, pair_we;
  logic [RIDX_W-1:0] byte_idx, byte_rd_idx;
  logic [DATA_W-1:0] byte_d, byte_rd, a_val;
  logic [ADDR_W-1:0] pair_rd, pair_nxt, hl_val;

  acc_decode u_dec (.op_i(mem_rdata_i), .dec_o(dec_w));

  acc_regfile #(.RST_SP(RST_SP)) u_rf (
    .clk_i, .rst_ni,
    .byte_we_i(byte_we), .byte_idx_i(byte_idx), .byte_d_i(byte_d),
    .pair_we_i(pair_we), .pair_idx_i(ir_q.pair), .pair_d_i(pair_nxt),
    .byte_rd_idx_i(byte_rd_idx), .byte_rd_o(byte_rd),
    .pair_rd_idx_i(ir_q.pair), .pair_rd_o(pair_rd),
    .a_o(a_val), .hl_o(hl_val)
  );

  acc_addr_unit u_pc_au (.val_i(pc_q), .mode_i(pc_mode), .off_i(tmp_q), .res_o(pc_nxt));
  acc_addr_unit u_pair_au (.val_i(pair_rd), .mode_i(pair_mode), .off_i(tmp_q), .res_o(pair_nxt));

  always_comb begin
    case (ir_q.cc)
      CC_NZ:   cond_ok = !flag_z_q;
      CC_Z:    cond_ok = flag_z_q;
      CC_NC:   cond_ok = !flag_c_q;
      default: cond_ok = 1'b1;
    endcase
  end

  assign pc_mode = (state_q == ST_M3 && ir_q.kind == OP_JR) ? AU_REL : AU_INC;

  always_comb begin
    if (ir_q.kind == OP_PAIR) pair_mode = ir_q.down ? AU_DEC : AU_INC;
    else                      pair_mode = (ir_q.hl == HL_DOWN) ? AU_DEC : AU_INC;
  end

  always_comb begin
    state_d     = state_q;
    mem_addr_o  = pc_q;
    mem_we_o    = 1'b0;
    mem_wdata_o = a_val;
    byte_we     = 1'b0;
    byte_idx    = ir_q.dst;
    byte_d      = mem_rdata_i;
    byte_rd_idx = dec_w.src;
    pair_we     = 1'b0;
    pc_en       = 1'b0;
    tmp_en      = 1'b0;
    case (state_q)
      ST_FETCH: begin
        pc_en = 1'b1;
        case (dec_w.kind)
          OP_MOV: begin
            byte_we  = 1'b1;
            byte_idx = dec_w.dst;
            byte_d   = byte_rd;
          end
          OP_ILL:  state_d = ST_HALT;
          default: state_d = ST_M2;
        endcase
      end
      ST_M2: begin
        state_d = ST_FETCH;
        case (ir_q.kind)
          OP_LDI: begin
            pc_en   = 1'b1;
            byte_we = 1'b1;
          end
          OP_PAIR: pair_we = 1'b1;
          OP_STP: begin
            mem_addr_o = pair_rd;
            mem_we_o   = 1'b1;
            pair_we    = (ir_q.hl != HL_KEEP);
          end
          OP_LDP: begin
            mem_addr_o = pair_rd;
            byte_we    = 1'b1;
            byte_idx   = IDX_A;
            pair_we    = (ir_q.hl != HL_KEEP);
          end
          OP_STIM: begin
            pc_en   = 1'b1;
            tmp_en  = 1'b1;
            state_d = ST_M3;
          end
          OP_JR: begin
            pc_en   = 1'b1;
            tmp_en  = 1'b1;
            state_d = cond_ok ? ST_M3 : ST_FETCH;
          end
          default: ;
        endcase
      end
      ST_M3: begin
        state_d = ST_FETCH;
        if (ir_q.kind == OP_STIM) begin
          mem_addr_o  = hl_val;
          mem_we_o    = 1'b1;
          mem_wdata_o = tmp_q;
        end else begin
          pc_en = 1'b1;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_FETCH;
      pc_q     <= RST_PC;
      ir_q     <= '0;
      tmp_q    <= '0;
      ill_q    <= 1'b0;
      flag_z_q <= RST_FLAGS[FLAG_Z_BIT];
      flag_c_q <= RST_FLAGS[FLAG_C_BIT];
    end else begin
      state_q <= state_d;
      if (pc_en) pc_q <= pc_nxt;
      if (tmp_en) tmp_q <= mem_rdata_i;
      if (state_q == ST_FETCH) ir_q <= dec_w;
      if (state_d == ST_HALT) ill_q <= 1'b1;
    end
  end

  assign illegal_o = ill_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              mem_we_i,
  input logic              illegal_i,
  input state_e            state_i,
  input kind_e             kind_i,
  input logic              cond_ok_i
);
  p_ill_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_i |=> illegal_i);
  p_halt_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_i |-> !mem_we_i);
  p_halt_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_i |=> $stable(mem_addr_i));
  p_write_then_fetch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> (state_i == ST_FETCH && !mem_we_i));
  p_pair_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_M2 && kind_i == OP_PAIR) |-> !mem_we_i);
  p_jr_skip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_M2 && kind_i == OP_JR && !cond_ok_i) |=> state_i == ST_FETCH);
endmodule

bind acc_core acc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_i (mem_addr_o),
  .mem_we_i   (mem_we_o),
  .illegal_i  (illegal_o),
  .state_i    (state_q),
  .kind_i     (ir_q.kind),
  .cond_ok_i  (cond_ok)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;
  localparam logic [15:0] ORG = 16'h0100;
  localparam logic [15:0] SP0 = 16'h8000;
  localparam logic [7:0]  FLG = 8'h80;
  localparam int MAX_CYC = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr;
  logic [7:0]  wdata, rdata;
  logic        we, ill;

  always #5 clk = ~clk;

  acc_core #(.RST_PC(ORG), .RST_SP(SP0), .RST_FLAGS(FLG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_we_o(we), .illegal_o(ill)
  );

  logic [7:0] dmem [4096];
  logic [7:0] rmem [4096];
  assign rdata = dmem[addr[11:0]];
  always @(posedge clk) if (we) dmem[addr[11:0]] <= wdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [7:0]  r [8];
  logic [15:0] m_sp, m_pc;
  bit          m_halt = 0;
  logic [15:0] qa[$];
  logic        qw[$];
  logic [7:0]  qd[$];
  logic        qi[$];
  string       qt[$];

  function automatic logic [7:0] rd(input logic [15:0] a);
    return rmem[a[11:0]];
  endfunction

  function automatic logic [15:0] pget(input logic [1:0] p);
    if (p == 2'd3) return m_sp;
    return {r[{p, 1'b0}], r[{p, 1'b1}]};
  endfunction

  task automatic pset(input logic [1:0] p, input logic [15:0] v);
    if (p == 2'd3) m_sp = v;
    else begin r[{p, 1'b0}] = v[15:8]; r[{p, 1'b1}] = v[7:0]; end
  endtask

  task automatic push(input logic [15:0] a, input logic w, input logic [7:0] d,
                      input logic i, input string t);
    qa.push_back(a); qw.push_back(w); qd.push_back(d); qi.push_back(i); qt.push_back(t);
  endtask

  task automatic gen();
    logic [7:0] op, v;
    logic [15:0] p0, ad;
    bit taken;
    if (m_halt) begin push(m_pc, 0, 8'h00, 1, "R9"); return; end
    p0 = m_pc; op = rd(m_pc); m_pc = m_pc + 16'd1;
    case (op)
      8'h40, 8'h41: begin push(p0, 0, 0, 0, "R8"); r[0] = r[op[2:0]]; end
      8'h06, 8'h0E, 8'h16, 8'h1E, 8'h26, 8'h2E, 8'h3E: begin
        push(p0, 0, 0, 0, "R1"); push(m_pc, 0, 0, 0, "R2");
        r[op[5:3]] = rd(m_pc); m_pc = m_pc + 16'd1;
      end
      8'h02, 8'h12: begin
        ad = pget(op[5:4]); push(p0, 0, 0, 0, "R1"); push(ad, 1, r[7], 0, "R3");
        rmem[ad[11:0]] = r[7];
      end
      8'h0A, 8'h1A: begin
        ad = pget(op[5:4]); push(p0, 0, 0, 0, "R1"); push(ad, 0, 0, 0, "R3");
        r[7] = rd(ad);
      end
      8'h22, 8'h32: begin
        ad = pget(2); push(p0, 0, 0, 0, "R1"); push(ad, 1, r[7], 0, "R4");
        rmem[ad[11:0]] = r[7];
        pset(2, (op == 8'h22) ? ad + 16'd1 : ad - 16'd1);
      end
      8'h2A, 8'h3A: begin
        ad = pget(2); push(p0, 0, 0, 0, "R1"); push(ad, 0, 0, 0, "R4");
        r[7] = rd(ad);
        pset(2, (op == 8'h2A) ? ad + 16'd1 : ad - 16'd1);
      end
      8'h03, 8'h13, 8'h23, 8'h33, 8'h0B, 8'h1B, 8'h2B, 8'h3B: begin
        push(p0, 0, 0, 0, "R1"); push(m_pc, 0, 0, 0, "R5");
        pset(op[5:4], op[3] ? pget(op[5:4]) - 16'd1 : pget(op[5:4]) + 16'd1);
      end
      8'h36: begin
        push(p0, 0, 0, 0, "R1"); push(m_pc, 0, 0, 0, "R6");
        v = rd(m_pc); m_pc = m_pc + 16'd1;
        ad = pget(2); push(ad, 1, v, 0, "R6"); rmem[ad[11:0]] = v;
      end
      8'h18, 8'h20, 8'h28, 8'h30: begin
        taken = (op == 8'h18) || (op == 8'h20 && !FLG[7]) ||
                (op == 8'h28 && FLG[7]) || (op == 8'h30 && !FLG[4]);
        push(p0, 0, 0, 0, "R1"); push(m_pc, 0, 0, 0, "R7/R10");
        v = rd(m_pc); m_pc = m_pc + 16'd1;
        if (taken) begin
          push(m_pc, 0, 0, 0, "R7/R10");
          m_pc = m_pc + {{8{v[7]}}, v};
        end
      end
      default: begin push(p0, 0, 0, 0, "R9"); m_halt = 1; end
    endcase
  endtask

  task automatic chk_mem(input logic [15:0] a, input string t);
    n_chk++;
    if (dmem[a[11:0]] !== rmem[a[11:0]]) begin
      n_fail++;
      $display("FAIL %s mem[%h] actual=%h expected=%h", t, a, dmem[a[11:0]], rmem[a[11:0]]);
    end
  endtask

  logic [7:0] prog [$] = '{
    8'h3E, 8'h5A, 8'h06, 8'h02, 8'h0E, 8'h00, 8'h02, 8'h03, 8'h3E, 8'hA5, 8'h02,
    8'h0B, 8'h0B, 8'h0A,
    8'h16, 8'h03, 8'h1E, 8'h00, 8'h12, 8'h1B, 8'h1A,
    8'h26, 8'hFF, 8'h2E, 8'hFF, 8'h23, 8'h22, 8'h2B, 8'h2B, 8'h32,
    8'h26, 8'h02, 8'h2E, 8'h00, 8'h2A, 8'h3A, 8'h36, 8'hC3,
    8'h3B, 8'h33, 8'h33, 8'h40, 8'h41, 8'h0E, 8'h10, 8'h02,
    8'h18, 8'h02, 8'hFF, 8'hFF,
    8'h20, 8'hFE,
    8'h28, 8'h02, 8'hFF, 8'hFF,
    8'h30, 8'h02, 8'hFF, 8'hFF,
    8'h18, 8'h04, 8'h3E, 8'h11, 8'h18, 8'h02, 8'h18, 8'hFA, 8'h02,
    8'hD3
  };

  initial begin
    int idle;
    for (int i = 0; i < 4096; i++) begin dmem[i] = 8'h00; rmem[i] = 8'h00; end
    for (int i = 0; i < prog.size(); i++) begin
      dmem[ORG[11:0] + 12'(i)] = prog[i]; rmem[ORG[11:0] + 12'(i)] = prog[i];
    end
    dmem[12'h1FF] = 8'h33; rmem[12'h1FF] = 8'h33;
    dmem[12'h2FF] = 8'h77; rmem[12'h2FF] = 8'h77;
    for (int i = 0; i < 8; i++) r[i] = 8'h00;
    m_sp = SP0; m_pc = ORG;

    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;  // R1 reset state
    if (addr !== ORG || we !== 1'b0 || ill !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset addr/we/ill actual=%h/%b/%b expected=%h/0/0", addr, we, ill, ORG);
    end
    rst_n = 1'b1;

    idle = 0;
    for (int cyc = 0; cyc < MAX_CYC && idle < 10; cyc++) begin
      logic [15:0] ea; logic ew, ei; logic [7:0] ed; string et;
      if (qa.size() == 0) gen();
      ea = qa.pop_front(); ew = qw.pop_front(); ed = qd.pop_front();
      ei = qi.pop_front(); et = qt.pop_front();
      n_chk++;
      if (addr !== ea || we !== ew || ill !== ei || (ew && wdata !== ed)) begin
        n_fail++;
        $display("FAIL %s cycle %0d addr/we/wdata/ill actual=%h/%b/%h/%b expected=%h/%b/%h/%b",
                 et, cyc, addr, we, wdata, ill, ea, ew, ed, ei);
      end
      if (ei) idle++;
      @(negedge clk);
    end
    if (idle < 10) begin
      n_chk++; n_fail++;
      $display("FAIL R9 core never halted actual=%0d expected=10", idle);
    end

    chk_mem(16'h0000, "R4");
    chk_mem(16'h0FFF, "R4");
    chk_mem(16'h0200, "R6");
    chk_mem(16'h0201, "R3");
    chk_mem(16'h0300, "R3");
    chk_mem(16'h0F10, "R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule